// File: doc/BRIEF.md
# Replica Agreement Voter with Segment Retry

The voter sits beside a group of replica processors that all execute the same job. At a compare point each replica's result word is delivered over a single shared port, one word per cycle, tagged with the replica's index. When every replica has delivered, the block looks for any two results that are equal. If it finds such a pair, the shared value is taken as correct: an accept pulse is raised, the value is presented, and a mask marks every replica that produced it. If no two results agree, a retry pulse tells all replicas to run the work again.

A job may be split into a number of equal segments, with one vote at the end of each. A failed vote repeats only the current segment; an accepted vote moves on to the next one, and the accept of the final segment also signals the end of the job. With a single segment the block acts as a plain end-of-job voter. Wrong results are assumed never to be equal to one another, so any agreeing pair is trusted. When several unequal pairs exist, the pair found from the lowest-indexed replica wins. Fewer than three replicas is refused when the block is elaborated.

Top module: `replica_voter`

## Requirements
- R1: After reset, or on a later reset, accept_o, retry_o and job_done_o are 0, voted_o and agree_mask_o are all zeros and seg_o is 0.
- R2: A result is stored at the replica slot given by res_idx_i. The vote starts only when every slot 0..NUM_REPLICAS-1 has been written since the last outcome. Writing a slot again before that replaces its earlier value.
- R3: If at least two stored results are equal, accept_o pulses high for one cycle. voted_o then carries the agreed value, and bit j of agree_mask_o is 1 exactly when replica j holds that value.
- R4: If no two stored results are equal, retry_o pulses high for one cycle and agree_mask_o becomes zero. voted_o keeps the last accepted value.
- R5: When several unequal values each have a matching pair, the accepted value is the one held by the lowest replica index that has an equal partner.
- R6: Let E0 be the clock edge that stores the last missing result. An accept for a winning lowest index k appears after edge E0+k+1. A retry appears after edge E0+NUM_REPLICAS-1. accept_o and retry_o are never high together.
- R7: A write is ignored, and leaves the outcome unchanged, if it arrives while a vote is in progress (from E0 up to and including the outcome edge) or if its index is NUM_REPLICAS or above.
- R8: seg_o advances by one on each accept and holds on a retry. The accept in segment NUM_SEGS-1 also raises job_done_o for that cycle and returns seg_o to 0.
- R9: With NUM_SEGS = 1, every accept raises job_done_o and seg_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| res_valid_i | input | 1 | Result word present this cycle |
| res_idx_i | input | IDX_W | Index of the replica delivering the word |
| res_data_i | input | DATA_W | Result word |
| accept_o | output | 1 | One-cycle pulse: agreeing pair found |
| retry_o | output | 1 | One-cycle pulse: no agreement, all replicas re-execute |
| voted_o | output | DATA_W | Last accepted value |
| agree_mask_o | output | NUM_REPLICAS | Replicas holding the accepted value |
| seg_o | output | SEG_W | Index of the segment under vote |
| job_done_o | output | 1 | One-cycle pulse with the accept of the last segment |

## Verification
Two things can meet in one cycle: a new result write and the vote search, which includes the edge where the outcome is issued and the slots are cleared. The bench keeps res_valid_i high during every search cycle of one vote. It drives a value that would create a matching pair if it were stored, and expects the retry that the stored values call for. The next vote must then start only after all replicas have written again. The accept of the final segment, which also wraps the segment counter and raises the job-done pulse, is judged in the same sample as the accepted value.

// File: rtl/voter_pkg.sv
package voter_pkg;
  typedef enum logic [1:0] {
    OUT_NONE   = 2'd0,
    OUT_ACCEPT = 2'd1,
    OUT_RETRY  = 2'd2
  } vote_out_e;
endpackage

// File: rtl/result_store.sv
module result_store #(
  parameter int unsigned NUM_REPLICAS = 5,
  parameter int unsigned DATA_W       = 16,
  localparam int unsigned IDX_W       = $clog2(NUM_REPLICAS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              clr_i,
  output logic [DATA_W-1:0] data_o [NUM_REPLICAS],
  output logic              full_o
);
  logic [DATA_W-1:0]       mem_q [NUM_REPLICAS];
  logic [NUM_REPLICAS-1:0] got_q;
  logic                    idx_ok;

  assign idx_ok = (32'(wr_idx_i) < NUM_REPLICAS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      got_q <= '0;
      for (int i = 0; i < int'(NUM_REPLICAS); i++) mem_q[i] <= '0;
    end else if (clr_i) begin
      got_q <= '0;
    end else if (wr_en_i && idx_ok) begin
      mem_q[wr_idx_i] <= wr_data_i;
      got_q[wr_idx_i] <= 1'b1;
    end
  end

  assign data_o = mem_q;
  assign full_o = &got_q;
endmodule

// File: rtl/pair_search.sv
module pair_search #(
  parameter int unsigned NUM_REPLICAS = 5,
  parameter int unsigned DATA_W       = 16,
  localparam int unsigned IDX_W       = $clog2(NUM_REPLICAS)
) (
  input  logic [DATA_W-1:0]       data_i [NUM_REPLICAS],
  input  logic [IDX_W-1:0]        anchor_i,
  output logic                    hit_o,
  output logic [NUM_REPLICAS-1:0] eq_o,
  output logic [DATA_W-1:0]       value_o
);
  logic [NUM_REPLICAS-1:0] self_sel;

  assign value_o = data_i[anchor_i];

  // earlier anchors already failed, so any other equal slot is a pair
  for (genvar j = 0; j < int'(NUM_REPLICAS); j++) begin : g_cmp
    assign eq_o[j]     = (data_i[j] == value_o);
    assign self_sel[j] = (anchor_i == IDX_W'(j));
  end

  assign hit_o = |(eq_o & ~self_sel);
endmodule

// File: rtl/segment_ctrl.sv
module segment_ctrl #(
  parameter int unsigned NUM_SEGS = 4,
  localparam int unsigned SEG_W   = (NUM_SEGS > 1) ? $clog2(NUM_SEGS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [SEG_W-1:0] seg_o,
  output logic             last_o
);
  localparam logic [SEG_W-1:0] SEG_LAST = SEG_W'(NUM_SEGS - 1);

  logic [SEG_W-1:0] seg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     seg_q <= '0;
    else if (adv_i)  seg_q <= (seg_q == SEG_LAST) ? '0 : seg_q + 1'b1;
  end

  assign seg_o  = seg_q;
  assign last_o = (seg_q == SEG_LAST);
endmodule

// File: rtl/replica_voter.sv
module replica_voter
  import voter_pkg::*;
#(
  parameter int unsigned NUM_REPLICAS = 5,
  parameter int unsigned DATA_W       = 16,
  parameter int unsigned NUM_SEGS     = 4,
  localparam int unsigned IDX_W       = $clog2(NUM_REPLICAS),
  localparam int unsigned SEG_W       = (NUM_SEGS > 1) ? $clog2(NUM_SEGS) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    res_valid_i,
  input  logic [IDX_W-1:0]        res_idx_i,
  input  logic [DATA_W-1:0]       res_data_i,
  output logic                    accept_o,
  output logic                    retry_o,
  output logic [DATA_W-1:0]       voted_o,
  output logic [NUM_REPLICAS-1:0] agree_mask_o,
  output logic [SEG_W-1:0]        seg_o,
  output logic                    job_done_o
);
  if (NUM_REPLICAS < 3) begin : g_bad_cfg
    $error("replica_voter needs at least three replicas");
  end

  localparam logic [IDX_W-1:0] LAST_ANCHOR = IDX_W'(NUM_REPLICAS - 2);

  logic [DATA_W-1:0]       slot_data [NUM_REPLICAS];
  logic                    busy;
  logic [IDX_W-1:0]        anchor_q;
  logic                    hit;
  logic [NUM_REPLICAS-1:0] eq_mask;
  logic [DATA_W-1:0]       cand;
  logic                    seg_last;
  vote_out_e               outcome;

  always_comb begin
    outcome = OUT_NONE;
    if (busy) begin
      if (hit)                          outcome = OUT_ACCEPT;
      else if (anchor_q == LAST_ANCHOR) outcome = OUT_RETRY;
    end
  end

  result_store #(.NUM_REPLICAS(NUM_REPLICAS), .DATA_W(DATA_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (res_valid_i && !busy),
    .wr_idx_i  (res_idx_i),
    .wr_data_i (res_data_i),
    .clr_i     (outcome != OUT_NONE),
    .data_o    (slot_data),
    .full_o    (busy)
  );

  pair_search #(.NUM_REPLICAS(NUM_REPLICAS), .DATA_W(DATA_W)) u_search (
    .data_i   (slot_data),
    .anchor_i (anchor_q),
    .hit_o    (hit),
    .eq_o     (eq_mask),
    .value_o  (cand)
  );

  segment_ctrl #(.NUM_SEGS(NUM_SEGS)) u_seg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (outcome == OUT_ACCEPT),
    .seg_o  (seg_o),
    .last_o (seg_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      anchor_q     <= '0;
      accept_o     <= 1'b0;
      retry_o      <= 1'b0;
      job_done_o   <= 1'b0;
      voted_o      <= '0;
      agree_mask_o <= '0;
    end else begin
      accept_o   <= 1'b0;
      retry_o    <= 1'b0;
      job_done_o <= 1'b0;
      unique case (outcome)
        OUT_ACCEPT: begin
          accept_o     <= 1'b1;
          job_done_o   <= seg_last;
          voted_o      <= cand;
          agree_mask_o <= eq_mask;
          anchor_q     <= '0;
        end
        OUT_RETRY: begin
          retry_o      <= 1'b1;
          agree_mask_o <= '0;
          anchor_q     <= '0;
        end
        default: if (busy) anchor_q <= anchor_q + 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/voter_checker.sv
module voter_checker #(
  parameter int unsigned NUM_REPLICAS = 5,
  parameter int unsigned DATA_W       = 16,
  parameter int unsigned NUM_SEGS     = 4,
  localparam int unsigned SEG_W       = (NUM_SEGS > 1) ? $clog2(NUM_SEGS) : 1
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    accept_o,
  input logic                    retry_o,
  input logic [DATA_W-1:0]       voted_o,
  input logic [NUM_REPLICAS-1:0] agree_mask_o,
  input logic [SEG_W-1:0]        seg_o,
  input logic                    job_done_o
);
  a_r6_excl_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(accept_o && retry_o));

  a_r3_pair_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> $countones(agree_mask_o) >= 2);

  a_r4_retry_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_o |-> agree_mask_o == '0);

  a_r4_voted_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_o |-> $stable(voted_o));

  a_r8_retry_seg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_o |-> $stable(seg_o));

  a_r8_done_wraps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    job_done_o |-> accept_o && seg_o == '0);

  a_r8_seg_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && !job_done_o) |-> seg_o == SEG_W'($past(seg_o) + 1'b1));
endmodule

bind replica_voter voter_checker #(
  .NUM_REPLICAS (NUM_REPLICAS),
  .DATA_W       (DATA_W),
  .NUM_SEGS     (NUM_SEGS)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .accept_o     (accept_o),
  .retry_o      (retry_o),
  .voted_o      (voted_o),
  .agree_mask_o (agree_mask_o),
  .seg_o        (seg_o),
  .job_done_o   (job_done_o)
);

// File: tb/replica_voter_bench.sv
module replica_voter_bench;
  localparam int N = 5;
  localparam int W = 16;
  localparam int S = 4;
  localparam int IW = $clog2(N);
  localparam int SW = $clog2(S);

  // columns: r0..r4, expect accept, expected value
  localparam logic [15:0] TBL [10][7] = '{
    '{16'h1111, 16'h1111, 16'h1111, 16'h1111, 16'h1111, 16'd1, 16'h1111},
    '{16'h0001, 16'h0001, 16'h0002, 16'h0003, 16'h0004, 16'd1, 16'h0001},
    '{16'h0005, 16'h0006, 16'h0007, 16'h0008, 16'h0005, 16'd1, 16'h0005},
    '{16'h0009, 16'h000a, 16'h000b, 16'h000c, 16'h000c, 16'd1, 16'h000c},
    '{16'h0001, 16'h0002, 16'h0003, 16'h0004, 16'h0005, 16'd0, 16'h0000},
    '{16'h0007, 16'h0008, 16'h0008, 16'h0007, 16'h0009, 16'd1, 16'h0007},
    '{16'h0003, 16'h0004, 16'h0004, 16'h0003, 16'h0003, 16'd1, 16'h0003},
    '{16'h0000, 16'hffff, 16'h1234, 16'hffff, 16'h0000, 16'd1, 16'h0000},
    '{16'h0002, 16'h0003, 16'h0004, 16'h0003, 16'h0005, 16'd1, 16'h0003},
    '{16'h00a0, 16'h00b0, 16'h00c0, 16'h00d0, 16'h00e0, 16'd0, 16'h0000}
  };

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          res_valid = 1'b0;
  logic [IW-1:0] res_idx = '0;
  logic [W-1:0]  res_data = '0;
  logic          accept, retry, job_done;
  logic [W-1:0]  voted;
  logic [N-1:0]  mask;
  logic [SW-1:0] seg;

  logic          s_valid = 1'b0;
  logic [1:0]    s_idx = '0;
  logic [W-1:0]  s_data = '0;
  logic          s_accept, s_retry, s_done;
  logic [W-1:0]  s_voted;
  logic [2:0]    s_mask;
  logic          s_seg;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;
  bit finished = 0;
  logic [W-1:0] cur [N];
  int exp_seg = 0;
  logic [W-1:0] last_val = '0;

  always #10 clk = ~clk;

  replica_voter #(.NUM_REPLICAS(N), .DATA_W(W), .NUM_SEGS(S)) u_replica_voter (
    .clk_i(clk), .rst_ni(rst_ni), .res_valid_i(res_valid), .res_idx_i(res_idx),
    .res_data_i(res_data), .accept_o(accept), .retry_o(retry), .voted_o(voted),
    .agree_mask_o(mask), .seg_o(seg), .job_done_o(job_done));

  replica_voter #(.NUM_REPLICAS(3), .DATA_W(W), .NUM_SEGS(1)) u_replica_voter_single (
    .clk_i(clk), .rst_ni(rst_ni), .res_valid_i(s_valid), .res_idx_i(s_idx),
    .res_data_i(s_data), .accept_o(s_accept), .retry_o(s_retry), .voted_o(s_voted),
    .agree_mask_o(s_mask), .seg_o(s_seg), .job_done_o(s_done));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send(int idx, logic [W-1:0] d);
    @(negedge clk);
    res_valid = 1'b1;
    res_idx   = IW'(idx);
    res_data  = d;
  endtask

  // returns edges after the storing edge until an outcome, 0 if none
  task automatic wait_out(bit junk, output int lat);
    lat = 0;
    @(negedge clk);
    res_valid = junk;
    res_idx   = '0;
    res_data  = cur[1];
    for (int k = 1; k <= N + 2; k++) begin
      @(negedge clk);
      if (accept || retry) begin
        lat = k;
        break;
      end
    end
    res_valid = 1'b0;
  endtask

  function automatic int find_anchor();
    for (int i = 0; i < N; i++)
      for (int j = i + 1; j < N; j++)
        if (cur[i] == cur[j]) return i;
    return -1;
  endfunction

  // judge the sampled outcome against the requirement model
  task automatic judge(int lat, string ctx);
    int a;
    logic [N-1:0] em;
    a = find_anchor();
    em = '0;
    if (a >= 0) for (int j = 0; j < N; j++) em[j] = (cur[j] == cur[a]);
    if (a >= 0) begin
      chk({"R3 accept ", ctx}, {accept, retry}, 2'b10);
      chk({"R3 R5 value ", ctx}, voted, cur[a]);
      chk({"R3 mask ", ctx}, mask, em);
      chk({"R6 latency ", ctx}, lat, a + 1);
      chk({"R8 job_done ", ctx}, job_done, (exp_seg == S - 1));
      exp_seg = (exp_seg + 1) % S;
      last_val = cur[a];
    end else begin
      chk({"R4 retry ", ctx}, {accept, retry}, 2'b01);
      chk({"R4 mask ", ctx}, mask, 0);
      chk({"R4 voted hold ", ctx}, voted, last_val);
      chk({"R6 latency ", ctx}, lat, N - 1);
      chk({"R8 no done ", ctx}, job_done, 0);
    end
    chk({"R8 seg ", ctx}, seg, exp_seg);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL R6 watchdog: actual %0d expected 0", cycles);
      summary();
      $finish;
    end
  end

  initial begin
    int lat;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {accept, retry, job_done, mask, seg}, 0);
    chk("R1 reset voted", voted, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 after release", {accept, retry, job_done, mask, seg, voted}, 0);

    // table of votes, odd rows deliver in reverse order
    for (int r = 0; r < 10; r++) begin
      for (int j = 0; j < N; j++) cur[j] = TBL[r][j];
      chk("R3 R4 table model", (find_anchor() >= 0), TBL[r][5][0]);
      if (find_anchor() >= 0) chk("R3 table value", cur[find_anchor()], TBL[r][6]);
      for (int j = 0; j < N; j++) begin
        int ix;
        ix = (r % 2 == 1) ? (N - 1 - j) : j;
        send(ix, cur[ix]);
      end
      wait_out(1'b0, lat);
      judge(lat, $sformatf("row %0d", r));
    end

    // R2 rewrite of slot 0 before completion replaces the value
    cur[0] = 16'h0bbb; cur[1] = 16'h0bbb; cur[2] = 16'h0001; cur[3] = 16'h0002; cur[4] = 16'h0003;
    send(0, 16'h5555);
    send(0, 16'h0bbb);
    send(1, cur[1]);
    send(2, cur[2]);
    send(3, cur[3]);
    @(negedge clk); res_valid = 1'b0;
    repeat (N + 2) begin
      @(negedge clk);
      if (accept || retry) chk("R2 no early vote", 1, 0);
    end
    send(4, cur[4]);
    wait_out(1'b0, lat);
    judge(lat, "R2 rewrite");

    // R7 out-of-range index is dropped
    cur[0] = 16'h0010; cur[1] = 16'h0020; cur[2] = 16'h0030; cur[3] = 16'h0040; cur[4] = 16'h0050;
    send(0, cur[0]); send(1, cur[1]); send(2, cur[2]); send(3, cur[3]);
    send(5, 16'h0010); send(6, 16'h0020); send(7, 16'h0030);
    send(4, cur[4]);
    wait_out(1'b0, lat);
    judge(lat, "R7 bad index");

    // R7 writes during the search and on the outcome edge are dropped
    cur[0] = 16'h0100; cur[1] = 16'h0200; cur[2] = 16'h0300; cur[3] = 16'h0400; cur[4] = 16'h0500;
    for (int j = 0; j < N; j++) send(j, cur[j]);
    wait_out(1'b1, lat);
    judge(lat, "R7 busy write");
    cur[0] = 16'h0777; cur[1] = 16'h0888; cur[2] = 16'h0999; cur[3] = 16'h0777; cur[4] = 16'h0aaa;
    for (int j = 0; j < N - 1; j++) send(j, cur[j]);
    @(negedge clk); res_valid = 1'b0;
    repeat (N + 2) begin
      @(negedge clk);
      if (accept || retry) chk("R7 slots cleared", 1, 0);
    end
    send(N - 1, cur[N - 1]);
    wait_out(1'b0, lat);
    judge(lat, "R7 after busy");

    // R1 reset in mid job
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk);
    chk("R1 mid reset", {accept, retry, job_done, mask, seg, voted}, 0);
    rst_ni = 1'b1;
    exp_seg = 0;
    last_val = '0;

    // R9 single segment, three replicas
    for (int v = 0; v < 2; v++) begin
      int got;
      got = 0;
      for (int j = 0; j < 3; j++) begin
        @(negedge clk);
        s_valid = 1'b1;
        s_idx   = 2'(j);
        s_data  = (v == 0) ? ((j == 1) ? 16'h0042 : 16'h0099) : 16'(j);
      end
      @(negedge clk); s_valid = 1'b0;
      for (int k = 1; k <= 5; k++) begin
        @(negedge clk);
        if (s_accept || s_retry) begin
          got = 1;
          if (v == 0) begin
            chk("R9 accept", {s_accept, s_retry, s_done}, 3'b101);
            chk("R9 value", s_voted, 16'h0099);
            chk("R9 mask", s_mask, 3'b101);
          end else begin
            chk("R9 retry", {s_accept, s_retry, s_done}, 3'b010);
          end
          chk("R9 seg", s_seg, 0);
          break;
        end
      end
      chk("R9 outcome seen", got, 1);
    end

    finished = 1;
    summary();
    $finish;
  end
endmodule